// File: doc/BRIEF.md
# Rate-Shaped Batch Crossbar Scheduler

This block picks the crossbar settings for an N-by-N switch that queues cells at both its inputs and its outputs and gives each input/output pair a reserved bandwidth trunk. Each pair has a programmed integer rate, given in cells per frame of `FRAME` slots. The block takes the greatest common divisor `g` of the frame length and all non-zero rates. Time is then cut into intervals of `FRAME/g` slots, and each pair may admit `rate/g` cells per interval.

Arrivals are pulses, one per pair and slot. An arrival counts toward the pair's current interval while the allowance holds out. Cells beyond the allowance wait in a pending count and are let in at later interval starts. At each interval start the admitted cells of the interval just ended join the eligible batch. The fabric runs at twice the line rate, so every slot has two matching phases. Each phase makes a greedy maximal matching over the pairs whose eligible count is still non-zero, and every grant takes one cell off that pair's count. When the rates are admissible, this clears every batch before the next one arrives.

Top module: `rsbm_sched`

## Requirements
- R1: A synchronous active-low reset clears all counters, the interval timer, the start pointer, both configuration outputs and `overflow`. All of them read zero on the first sample after a reset edge.
- R2: The interval length is `FRAME/g` slots. Here `g` is the GCD of `FRAME` and every non-zero rate. A pair's per-interval allowance is `rate/g`. With all rates zero, every slot is an interval boundary and the allowance is zero.
- R3: An arrival within the pair's allowance for the current interval becomes eligible at the next boundary edge. It can be granted in the slot that follows that edge.
- R4: An arrival beyond the allowance is added to the pair's pending count. At each boundary, up to one allowance of pending cells moves into the new interval's admitted count, ahead of any arrival in that same slot.
- R5: In `cfg_a` and in `cfg_b`, bit `i*N+j` connects input i to output j. Each input row and each output column has at most one bit set.
- R6: Each phase is maximal. For every pair with a non-zero count offered to that phase, its input or its output is connected in that phase.
- R7: Phase A serves inputs in order starting at pointer `s`, and phase B starts at `s+1` (mod N). The pointer is 0 after reset and advances by 2 (mod N) every slot. Each input takes its lowest-indexed requesting output that is still free.
- R8: Phase B sees each pair's eligible count less its phase A grant. Each grant takes one cell off the pair's eligible count, and no grant is given to a pair with an empty count.
- R9: Counters saturate at `2^CNT_W-1` and never wrap. In the slot after a pending or eligible count would have gone past that value, `overflow` is high for one cycle.
- R10: Both configurations and `overflow` are registered. They show the decision made from the state held during the previous slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rate_cfg | input | N*N*RATE_W | Rate of pair p = i*N+j at bits p*RATE_W upward |
| arrive | input | N*N | One cell arrival pulse per pair and slot |
| cfg_a | output | N*N | First-phase crossbar setting, bit i*N+j |
| cfg_b | output | N*N | Second-phase crossbar setting, bit i*N+j |
| overflow | output | 1 | A counter saturated in the previous slot |

## Verification
An arrival sampled at edge k that fits its allowance reaches the eligible count at the first boundary edge at or after k+1. It appears on `cfg_a` or `cfg_b` one edge after that. For example, with period 4 after reset, an arrival at edge 1 is granted on the outputs after edge 5. The bench drives inputs and samples outputs on the falling edge. A bench model is advanced once per slot at that edge, so each compared value belongs to the edge just passed. Directed runs check the exact grant cycles for in-allowance and pending cells. Swept runs over several rate patterns compare every output every cycle and check row/column exclusivity and maximality against the eligible state of the slot before.

// File: rtl/rsbm_pkg.sv
// Shared helpers for the rate-shaped batch scheduler.
// Assumes: operands fit in 32 bits.
package rsbm_pkg;
    // Greatest common divisor by bounded Euclid; gcd(a,0)=a
    function automatic int unsigned gcd_u(input int unsigned a, input int unsigned b);
        int unsigned x;
        int unsigned y;
        int unsigned t;
        x = a;
        y = b;
        for (int k = 0; k < 48; k++) begin
            if (y != 0) begin
                t = x % y;
                x = y;
                y = t;
            end
        end
        return x;
    endfunction
endpackage

// File: rtl/rsbm_interval_timer.sv
// Interval timer: counts slots and flags the last slot of each interval.
// Assumes: period >= 1; a shortened period ends the running interval at once.
module rsbm_interval_timer #(
    parameter int FRAME_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FRAME_W-1:0] period,
    output logic               boundary
);
    logic [FRAME_W-1:0] tmr_q;

    // Last slot of the interval
    assign boundary = (tmr_q >= period - 1'b1);

    // Advance or wrap the slot count
    always_ff @(posedge clk) begin
        if (!rst_n)        tmr_q <= '0;
        else if (boundary) tmr_q <= '0;
        else               tmr_q <= tmr_q + 1'b1;
    end
endmodule

// File: rtl/rsbm_pair_counter.sv
// Per-pair shaping counters: admitted-this-interval, pending excess and
// eligible batch. Assumes CNT_W >= RATE_W, CNT_W >= 2, served <= eligible.
module rsbm_pair_counter #(
    parameter int RATE_W = 4,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boundary,
    input  logic              arrive,
    input  logic [RATE_W-1:0] allow,
    input  logic [1:0]        served,
    output logic              nz,
    output logic              ge2,
    output logic              ovf
);
    localparam logic [CNT_W-1:0] MAXC = {CNT_W{1'b1}};

    logic [CNT_W-1:0] elig_q, acc_q, pend_q;
    logic [CNT_W-1:0] elig_n, acc_n, pend_n;
    logic [CNT_W-1:0] rem, mv, acc_b, pend_b, lim;
    logic [CNT_W:0]   sum;

    assign nz  = (elig_q != '0);
    assign ge2 = (elig_q > CNT_W'(1));
    assign lim = CNT_W'(allow);

    // Next-state of all three counters, with saturation detection
    always_comb begin
        rem    = elig_q - CNT_W'(served);
        mv     = (pend_q < lim) ? pend_q : lim;
        sum    = {1'b0, rem} + {1'b0, acc_q};
        ovf    = 1'b0;
        elig_n = rem;
        acc_b  = acc_q;
        pend_b = pend_q;
        if (boundary) begin
            if (sum > {1'b0, MAXC}) begin
                elig_n = MAXC;
                ovf    = 1'b1;
            end else begin
                elig_n = sum[CNT_W-1:0];
            end
            acc_b  = mv;
            pend_b = pend_q - mv;
        end
        acc_n  = acc_b;
        pend_n = pend_b;
        if (arrive) begin
            if (acc_b < lim)        acc_n  = acc_b + 1'b1;
            else if (pend_b == MAXC) ovf   = 1'b1;
            else                     pend_n = pend_b + 1'b1;
        end
    end

    // Counter registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elig_q <= '0;
            acc_q  <= '0;
            pend_q <= '0;
        end else begin
            elig_q <= elig_n;
            acc_q  <= acc_n;
            pend_q <= pend_n;
        end
    end
endmodule

// File: rtl/rsbm_greedy_matcher.sv
// Greedy maximal matcher: inputs visited from `start` in rotating order,
// each takes its lowest-indexed free requested output. Purely combinational.
module rsbm_greedy_matcher #(
    parameter int N     = 4,
    parameter int PTR_W = 2
) (
    input  logic [N*N-1:0] req,
    input  logic [PTR_W-1:0] start,
    output logic [N*N-1:0] grant
);
    logic [N-1:0] used;

    // Single greedy pass over inputs
    always_comb begin
        grant = '0;
        used  = '0;
        for (int k = 0; k < N; k++) begin
            int  i;
            logic taken;
            i     = (int'(start) + k) % N;
            taken = 1'b0;
            for (int j = 0; j < N; j++) begin
                if (!taken && req[i*N+j] && !used[j]) begin
                    grant[i*N+j] = 1'b1;
                    used[j]      = 1'b1;
                    taken        = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rsbm_sched.sv
// Rate-shaped batch scheduler top: derives interval and allowances from the
// rate matrix, keeps per-pair counters, runs two matching phases per slot.
// Assumes rate_cfg held stable between resets and admissible for clearing.
module rsbm_sched #(
    parameter int N      = 4,
    parameter int RATE_W = 4,
    parameter int CNT_W  = 4,
    parameter int FRAME  = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N*N*RATE_W-1:0] rate_cfg,
    input  logic [N*N-1:0]        arrive,
    output logic [N*N-1:0]        cfg_a,
    output logic [N*N-1:0]        cfg_b,
    output logic                  overflow
);
    import rsbm_pkg::*;

    localparam int NP      = N * N;
    localparam int FRAME_W = $clog2(FRAME + 1);
    localparam int PTR_W   = (N > 1) ? $clog2(N) : 1;

    logic [FRAME_W-1:0] period;
    logic [RATE_W-1:0]  allow [NP];
    logic               bnd;
    logic [NP-1:0]      req_a, req_b, ge2, gnt_a, gnt_b, ovf_p;
    logic [PTR_W-1:0]   ptr_q, start_b;

    // Interval length and per-pair allowance from the GCD of the rates
    always_comb begin
        int unsigned g;
        g = FRAME;
        for (int p = 0; p < NP; p++)
            g = gcd_u(g, 32'(rate_cfg[p*RATE_W +: RATE_W]));
        period = FRAME_W'(FRAME / g);
        for (int p = 0; p < NP; p++)
            allow[p] = RATE_W'(32'(rate_cfg[p*RATE_W +: RATE_W]) / g);
    end

    rsbm_interval_timer #(.FRAME_W(FRAME_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .period(period), .boundary(bnd)
    );

    genvar p;
    generate
        for (p = 0; p < NP; p++) begin : g_pair
            rsbm_pair_counter #(.RATE_W(RATE_W), .CNT_W(CNT_W)) u_pc (
                .clk(clk), .rst_n(rst_n), .boundary(bnd),
                .arrive(arrive[p]), .allow(allow[p]),
                .served({1'b0, gnt_a[p]} + {1'b0, gnt_b[p]}),
                .nz(req_a[p]), .ge2(ge2[p]), .ovf(ovf_p[p])
            );
            // Count left for phase B after phase A's grant
            assign req_b[p] = ge2[p] | (req_a[p] & ~gnt_a[p]);
        end
    endgenerate

    assign start_b = PTR_W'((int'(ptr_q) + 1) % N);

    rsbm_greedy_matcher #(.N(N), .PTR_W(PTR_W)) u_match_a (
        .req(req_a), .start(ptr_q), .grant(gnt_a)
    );
    rsbm_greedy_matcher #(.N(N), .PTR_W(PTR_W)) u_match_b (
        .req(req_b), .start(start_b), .grant(gnt_b)
    );

    // Register configurations, overflow pulse and the rotating start pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q    <= '0;
            cfg_a    <= '0;
            cfg_b    <= '0;
            overflow <= 1'b0;
        end else begin
            ptr_q    <= PTR_W'((int'(ptr_q) + 2) % N);
            cfg_a    <= gnt_a;
            cfg_b    <= gnt_b;
            overflow <= |ovf_p;
        end
    end
endmodule

// File: rtl/rsbm_sched_chk.sv
// Property checker for rsbm_sched, attached by bind below.
module rsbm_sched_chk #(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N*N-1:0] cfg_a,
    input logic [N*N-1:0] cfg_b,
    input logic [N*N-1:0] nz
);
    // At most one grant per row and per column
    function automatic logic excl(input logic [N*N-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < N; i++) begin
            int rc;
            int cc;
            rc = 0;
            cc = 0;
            for (int j = 0; j < N; j++) begin
                rc += int'(v[i*N+j]);
                cc += int'(v[j*N+i]);
            end
            if (rc > 1 || cc > 1) ok = 1'b0;
        end
        return ok;
    endfunction

    // Every requesting pair sees its row or column used
    function automatic logic maximal(input logic [N*N-1:0] r, input logic [N*N-1:0] g);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
                logic hit;
                hit = 1'b0;
                for (int k = 0; k < N; k++)
                    hit = hit | g[i*N+k] | g[k*N+j];
                if (r[i*N+j] && !hit) ok = 1'b0;
            end
        return ok;
    endfunction

    AST_EXCL_A: assert property (@(posedge clk) disable iff (!rst_n)
        excl(cfg_a)); // R5
    AST_EXCL_B: assert property (@(posedge clk) disable iff (!rst_n)
        excl(cfg_b)); // R5
    AST_MAXIMAL_A: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> maximal($past(nz), cfg_a)); // R6
    AST_GRANT_NONEMPTY_A: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((cfg_a & ~$past(nz)) == '0)); // R8
    AST_GRANT_NONEMPTY_B: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((cfg_b & ~$past(nz)) == '0)); // R8
endmodule

bind rsbm_sched rsbm_sched_chk #(.N(N)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_a(cfg_a), .cfg_b(cfg_b), .nz(req_a)
);

// File: tb/rsbm_sched_test.sv
// Sweep bench for rsbm_sched on a 3x3 configuration with a slot-level model.
module rsbm_sched_test;
    localparam int N = 3, RW = 3, CW = 3, FR = 8, NP = N * N;
    localparam int MAXC = (1 << CW) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NP*RW-1:0]  rate_cfg = '0;
    logic [NP-1:0]     arrive = '0;
    logic [NP-1:0]     cfg_a, cfg_b;
    logic              overflow;

    int checks = 0, errors = 0;
    bit done = 0;
    int unsigned rng = 32'h1234_5678;

    int m_el[NP], m_acc[NP], m_pend[NP];
    int m_tmr, m_ptr;
    logic [NP-1:0] exp_a, exp_b, prev_nz;
    logic exp_ovf;

    rsbm_sched #(.N(N), .RATE_W(RW), .CNT_W(CW), .FRAME(FR)) uut (
        .clk(clk), .rst_n(rst_n), .rate_cfg(rate_cfg), .arrive(arrive),
        .cfg_a(cfg_a), .cfg_b(cfg_b), .overflow(overflow)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int gcd(input int a, input int b);
        while (b != 0) begin
            int t;
            t = a % b;
            a = b;
            b = t;
        end
        return a;
    endfunction

    function automatic logic [NP-1:0] greedy(input logic [NP-1:0] req, input int start);
        logic [NP-1:0] g;
        logic [N-1:0]  used;
        g = '0;
        used = '0;
        for (int k = 0; k < N; k++) begin
            int i;
            bit taken;
            i = (start + k) % N;
            taken = 0;
            for (int j = 0; j < N; j++)
                if (!taken && req[i*N+j] && !used[j]) begin
                    g[i*N+j] = 1'b1;
                    used[j] = 1'b1;
                    taken = 1;
                end
        end
        return g;
    endfunction

    function automatic bit excl_ok(input logic [NP-1:0] v);
        for (int i = 0; i < N; i++) begin
            int rc, cc;
            rc = 0;
            cc = 0;
            for (int j = 0; j < N; j++) begin
                rc += int'(v[i*N+j]);
                cc += int'(v[j*N+i]);
            end
            if (rc > 1 || cc > 1) return 0;
        end
        return 1;
    endfunction

    function automatic bit maximal_ok(input logic [NP-1:0] r, input logic [NP-1:0] g);
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
                bit hit;
                hit = 0;
                for (int k = 0; k < N; k++)
                    hit = hit | g[i*N+k] | g[k*N+j];
                if (r[i*N+j] && !hit) return 0;
            end
        return 1;
    endfunction

    function automatic int rate_of(input int p);
        return int'(rate_cfg[p*RW +: RW]);
    endfunction

    // Advance the slot model by one edge with the given arrivals (R2, R3, R4, R7, R8, R9)
    task automatic model_step(input logic [NP-1:0] arr);
        int g, per, allow[NP];
        bit bnd;
        logic [NP-1:0] nz, rb, ga, gb;
        logic ov;
        g = FR;
        for (int p = 0; p < NP; p++) g = gcd(g, rate_of(p));
        per = FR / g;
        for (int p = 0; p < NP; p++) allow[p] = rate_of(p) / g;
        bnd = (m_tmr >= per - 1);
        for (int p = 0; p < NP; p++) nz[p] = (m_el[p] > 0);
        ga = greedy(nz, m_ptr);
        for (int p = 0; p < NP; p++) rb[p] = (m_el[p] - int'(ga[p]) > 0);
        gb = greedy(rb, (m_ptr + 1) % N);
        ov = 1'b0;
        for (int p = 0; p < NP; p++) begin
            int rem, ab, pb;
            rem = m_el[p] - int'(ga[p]) - int'(gb[p]);
            ab = m_acc[p];
            pb = m_pend[p];
            if (bnd) begin
                int mv;
                if (rem + m_acc[p] > MAXC) begin m_el[p] = MAXC; ov = 1'b1; end
                else m_el[p] = rem + m_acc[p];
                mv = (m_pend[p] < allow[p]) ? m_pend[p] : allow[p];
                ab = mv;
                pb = m_pend[p] - mv;
            end else begin
                m_el[p] = rem;
            end
            if (arr[p]) begin
                if (ab < allow[p]) ab++;
                else if (pb == MAXC) ov = 1'b1;
                else pb++;
            end
            m_acc[p] = ab;
            m_pend[p] = pb;
        end
        m_tmr = bnd ? 0 : m_tmr + 1;
        m_ptr = (m_ptr + 2) % N;
        exp_a = ga;
        exp_b = gb;
        exp_ovf = ov;
        prev_nz = nz;
    endtask

    // Compare all outputs with the model for the edge just passed
    task automatic sample();
        chk(cfg_a == exp_a, "R7 cfg_a", 64'(cfg_a), 64'(exp_a));
        chk(cfg_b == exp_b, "R8 cfg_b", 64'(cfg_b), 64'(exp_b));
        chk(overflow == exp_ovf, "R9 overflow", 64'(overflow), 64'(exp_ovf));
        chk(excl_ok(cfg_a) && excl_ok(cfg_b), "R5 row/column", 64'({cfg_b, cfg_a}), 64'(0));
        chk(maximal_ok(prev_nz, cfg_a), "R6 maximal", 64'(cfg_a), 64'(prev_nz));
    endtask

    // Reset, check cleared outputs, release on a falling edge (R1)
    task automatic do_reset(input logic [NP*RW-1:0] rates);
        @(negedge clk);
        rst_n = 1'b0;
        arrive = '0;
        rate_cfg = rates;
        repeat (2) @(negedge clk);
        chk(cfg_a == '0 && cfg_b == '0 && overflow == 1'b0, "R1 reset",
            64'({overflow, cfg_b, cfg_a}), 64'(0));
        for (int p = 0; p < NP; p++) begin m_el[p] = 0; m_acc[p] = 0; m_pend[p] = 0; end
        m_tmr = 0;
        m_ptr = 0;
        rst_n = 1'b1;
    endtask

    function automatic logic [NP*RW-1:0] rates_fill(input int a, input int b);
        logic [NP*RW-1:0] r;
        for (int p = 0; p < NP; p++) r[p*RW +: RW] = RW'((p % 2 == 0) ? a : b);
        return r;
    endfunction

    function automatic logic [NP-1:0] rand_arr(input int thr);
        logic [NP-1:0] a;
        for (int p = 0; p < NP; p++) begin
            rng ^= rng << 13;
            rng ^= rng >> 17;
            rng ^= rng << 5;
            a[p] = (rng[7:0] < 8'(thr));
        end
        return a;
    endfunction

    task automatic run_sweep(input logic [NP*RW-1:0] rates, input int thr, input int cycles);
        do_reset(rates);
        arrive = rand_arr(thr);
        model_step(arrive);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            sample();
            arrive = rand_arr(thr);
            model_step(arrive);
        end
        @(negedge clk);
        sample();
        arrive = '0;
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // Directed: one in-allowance cell, period 4 -> granted after edge 5 (R2, R3, R10)
        do_reset(rates_fill(2, 2));
        arrive = NP'(1) << 1;
        model_step(arrive);
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            sample();
            chk(cfg_a[1] == (k == 5), "R3 R10 grant slot", 64'(cfg_a[1]), 64'(k == 5));
            arrive = '0;
            model_step(arrive);
        end

        // Directed: three cells, allowance 1 -> grants after edges 5, 9, 13 (R2, R4)
        do_reset(rates_fill(2, 2));
        for (int k = 1; k <= 16; k++) begin
            arrive = (k <= 3) ? NP'(1) : '0;
            model_step(arrive);
            @(negedge clk);
            sample();
            chk(cfg_a[0] == (k == 5 || k == 9 || k == 13), "R2 R4 pending release",
                64'(cfg_a[0]), 64'(k == 5 || k == 9 || k == 13));
        end
        arrive = '0;

        run_sweep(rates_fill(2, 2), 60, 300);
        run_sweep(rates_fill(2, 4), 90, 300);
        run_sweep(rates_fill(1, 1), 40, 300);
        run_sweep(rates_fill(3, 1), 80, 300);
        run_sweep(rates_fill(6, 4), 200, 300);
        run_sweep(rates_fill(0, 0), 120, 100);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule